// File: doc/BRIEF.md
# PS/2 Keyboard Host Receiver

This block sits on the host end of a PS/2 keyboard link and turns the serial traffic the keyboard sends into tagged key events. The keyboard drives the link clock. The receiver brings both open-collector lines into the system clock domain and rejects short clock glitches. It takes a data bit on each clean falling edge of the link clock. Each 11-bit frame is checked for framing and parity before its byte is accepted.

Accepted bytes go to a prefix tracker. The release marker (0xF0) and the extended marker (0xE0) are held until the next ordinary byte. That byte then comes out as a single event carrying the scan code, a release flag and an extended flag. The command acknowledge byte (0xFA) and the self-test-passed byte (0xAA) never show up as keys; each has its own strobe. Framing faults produce an error strobe.

Host logic that drives the link clock low to inhibit the keyboard also raises `inhibit_i`, which throws away any frame in progress. A long gap between clock edges drops a partial frame silently, so the next frame starts from a clean state.

Top module: `kbd_link_rx`

## Requirements
- R1: A frame is 11 bits taken on falling edges of the filtered link clock, in this order: a start bit of 0, eight data bits least significant first, an odd-parity bit (data plus parity hold an odd count of ones), and a stop bit of 1.
- R2: An accepted byte other than 0xE0, 0xF0, 0xFA or 0xAA produces exactly one one-cycle `key_valid_o` pulse, with `key_code_o` equal to the byte. When no prefix is pending, both flags are 0.
- R3: After byte 0xF0, the next ordinary byte is reported with `key_release_o` = 1.
- R4: After byte 0xE0, the next ordinary byte is reported with `key_ext_o` = 1. The sequence 0xE0 0xF0 code reports code with both flags set.
- R5: Both pending prefixes clear when a key event is emitted, so a following ordinary byte with no prefix comes out as a plain press.
- R6: Byte 0xFA pulses `ack_o` for one cycle, produces no key event and clears pending prefixes.
- R7: Byte 0xAA pulses `selftest_o` for one cycle, produces no key event and clears pending prefixes.
- R8: A frame with wrong parity or a stop bit of 0 pulses `frame_err_o` for one cycle, yields no byte and clears pending prefixes.
- R9: A start bit of 1 pulses `frame_err_o` at once, and the receiver stays waiting for a start bit.
- R10: While `inhibit_i` is 1, any partial frame is dropped and link clock edges are ignored. The next full frame after release is received correctly.
- R11: If more than `TIMEOUT_CYC` system cycles pass between falling edges inside a frame, the partial frame is dropped with no error strobe.
- R12: A link clock level that lasts fewer than `FILT_LEN` system cycles is ignored.
- R13: After reset, all output strobes and flags are 0 and the code is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ps2_clk_i | input | 1 | Link clock line level, asynchronous |
| ps2_dat_i | input | 1 | Link data line level, asynchronous |
| inhibit_i | input | 1 | Host is holding the link inhibited; aborts reception |
| key_valid_o | output | 1 | One-cycle key event strobe |
| key_code_o | output | 8 | Scan code of the event |
| key_release_o | output | 1 | Event is a key release |
| key_ext_o | output | 1 | Event carried the extended prefix |
| ack_o | output | 1 | One-cycle strobe: acknowledge byte received |
| selftest_o | output | 1 | One-cycle strobe: self-test-passed byte received |
| frame_err_o | output | 1 | One-cycle strobe: bad start, parity or stop |

## Verification
The assertions assume that the link clock stays at each level for much longer than `FILT_LEN` cycles once it has been accepted. They also assume that consecutive falling edges within a frame are closer together than `TIMEOUT_CYC`, so that at most one byte completes per edge. The stimulus changes data only while the link clock is high and uses a half period well between the filter length and the timeout. Glitches, long gaps and inhibit are applied only where a test calls for them.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;
  localparam int unsigned FRAME_BITS = 11;
  localparam int unsigned BODY_BITS  = FRAME_BITS - 1;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS);

  localparam logic [7:0] CODE_RELEASE  = 8'hF0;
  localparam logic [7:0] CODE_EXTENDED = 8'hE0;
  localparam logic [7:0] CODE_ACK      = 8'hFA;
  localparam logic [7:0] CODE_SELFTEST = 8'hAA;

  typedef logic [CNT_W-1:0] bit_idx_t;
endpackage

// File: rtl/kbd_rx_cond.sv
module kbd_rx_cond #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic line_clk_i,
  input  logic line_dat_i,
  output logic fall_o,
  output logic bit_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] clk_sr, dat_sr;
  logic                   filt_q;
  logic [CW-1:0]          run_q;
  logic                   c_s, d_s;

  assign c_s = clk_sr[SYNC_STAGES-1];
  assign d_s = dat_sr[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_sr <= '1;
      dat_sr <= '1;
    end else begin
      clk_sr <= {clk_sr[SYNC_STAGES-2:0], line_clk_i};
      dat_sr <= {dat_sr[SYNC_STAGES-2:0], line_dat_i};
    end
  end

  // Level changes only after FILT_LEN consecutive differing samples.
  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= 1'b1;
      run_q  <= '0;
      fall_o <= 1'b0;
      bit_o  <= 1'b1;
    end else begin
      fall_o <= 1'b0;
      if (c_s != filt_q) begin
        if (run_q == CW'(FILT_LEN - 1)) begin
          filt_q <= c_s;
          run_q  <= '0;
          fall_o <= ~c_s;
          bit_o  <= d_s;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  a_r12_fall_single: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);
endmodule

// File: rtl/kbd_rx_frame.sv
module kbd_rx_frame
  import kbd_rx_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 100000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fall_i,
  input  logic       bit_i,
  input  logic       inhibit_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       err_o
);
  localparam int unsigned GW = $clog2(TIMEOUT_CYC + 1);

  bit_idx_t               idx_q;
  logic [BODY_BITS-1:0]   sh_q;
  logic [GW-1:0]          gap_q;
  logic [BODY_BITS-1:0]   body;

  assign body = {bit_i, sh_q[BODY_BITS-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q      <= '0;
      sh_q       <= '0;
      gap_q      <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
      err_o      <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      err_o      <= 1'b0;
      if (inhibit_i) begin
        idx_q <= '0;
        gap_q <= '0;
      end else if (fall_i) begin
        gap_q <= '0;
        if (idx_q == '0) begin
          if (bit_i) err_o <= 1'b1;
          else       idx_q <= bit_idx_t'(1);
        end else begin
          sh_q <= body;
          if (idx_q == bit_idx_t'(BODY_BITS)) begin
            idx_q <= '0;
            if ((^body[8:0]) && body[9]) begin
              byte_vld_o <= 1'b1;
              byte_o     <= body[7:0];
            end else begin
              err_o <= 1'b1;
            end
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      end else if (idx_q != '0) begin
        if (gap_q == GW'(TIMEOUT_CYC - 1)) begin
          idx_q <= '0;
          gap_q <= '0;
        end else begin
          gap_q <= gap_q + 1'b1;
        end
      end else begin
        gap_q <= '0;
      end
    end
  end

  a_r1_idx_range: assert property (@(posedge clk) disable iff (rst)
    idx_q <= bit_idx_t'(BODY_BITS));
  a_r10_inhibit_drops: assert property (@(posedge clk) disable iff (rst)
    inhibit_i |=> (idx_q == '0) && !byte_vld_o && !err_o);
  a_r8_err_excl_byte: assert property (@(posedge clk) disable iff (rst)
    !(err_o && byte_vld_o));
endmodule

// File: rtl/kbd_rx_events.sv
module kbd_rx_events
  import kbd_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  input  logic       err_i,
  output logic       key_valid_o,
  output logic [7:0] key_code_o,
  output logic       key_release_o,
  output logic       key_ext_o,
  output logic       ack_o,
  output logic       selftest_o,
  output logic       err_o
);
  logic rel_q, ext_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_q         <= 1'b0;
      ext_q         <= 1'b0;
      key_valid_o   <= 1'b0;
      key_code_o    <= '0;
      key_release_o <= 1'b0;
      key_ext_o     <= 1'b0;
      ack_o         <= 1'b0;
      selftest_o    <= 1'b0;
      err_o         <= 1'b0;
    end else begin
      key_valid_o <= 1'b0;
      ack_o       <= 1'b0;
      selftest_o  <= 1'b0;
      err_o       <= err_i;
      if (err_i) begin
        rel_q <= 1'b0;
        ext_q <= 1'b0;
      end else if (byte_vld_i) begin
        unique case (byte_i)
          CODE_RELEASE:  rel_q <= 1'b1;
          CODE_EXTENDED: ext_q <= 1'b1;
          CODE_ACK: begin
            ack_o <= 1'b1;
            rel_q <= 1'b0;
            ext_q <= 1'b0;
          end
          CODE_SELFTEST: begin
            selftest_o <= 1'b1;
            rel_q      <= 1'b0;
            ext_q      <= 1'b0;
          end
          default: begin
            key_valid_o   <= 1'b1;
            key_code_o    <= byte_i;
            key_release_o <= rel_q;
            key_ext_o     <= ext_q;
            rel_q         <= 1'b0;
            ext_q         <= 1'b0;
          end
        endcase
      end
    end
  end

  a_r5_prefix_cleared: assert property (@(posedge clk) disable iff (rst)
    key_valid_o |-> !rel_q && !ext_q);
  a_r8_err_clears_prefix: assert property (@(posedge clk) disable iff (rst)
    err_i |=> !rel_q && !ext_q);
  a_r6_ack_not_key: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> !key_valid_o && !selftest_o);
endmodule

// File: rtl/kbd_link_rx.sv
module kbd_link_rx #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 8,
  parameter int unsigned TIMEOUT_CYC = 100000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  input  logic       inhibit_i,
  output logic       key_valid_o,
  output logic [7:0] key_code_o,
  output logic       key_release_o,
  output logic       key_ext_o,
  output logic       ack_o,
  output logic       selftest_o,
  output logic       frame_err_o
);
  logic       fall, smp_bit, byte_vld, ferr;
  logic [7:0] rx_byte;

  kbd_rx_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_cond (
    .clk(clk), .rst(rst), .line_clk_i(ps2_clk_i), .line_dat_i(ps2_dat_i),
    .fall_o(fall), .bit_o(smp_bit)
  );

  kbd_rx_frame #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_frame (
    .clk(clk), .rst(rst), .fall_i(fall), .bit_i(smp_bit), .inhibit_i(inhibit_i),
    .byte_vld_o(byte_vld), .byte_o(rx_byte), .err_o(ferr)
  );

  kbd_rx_events u_events (
    .clk(clk), .rst(rst), .byte_vld_i(byte_vld), .byte_i(rx_byte), .err_i(ferr),
    .key_valid_o(key_valid_o), .key_code_o(key_code_o),
    .key_release_o(key_release_o), .key_ext_o(key_ext_o),
    .ack_o(ack_o), .selftest_o(selftest_o), .err_o(frame_err_o)
  );

  a_r2_single_kind: assert property (@(posedge clk) disable iff (rst)
    $onehot0({key_valid_o, ack_o, selftest_o, frame_err_o}));
  a_r2_key_not_special: assert property (@(posedge clk) disable iff (rst)
    key_valid_o |-> key_code_o != 8'hF0 && key_code_o != 8'hE0 &&
                    key_code_o != 8'hFA && key_code_o != 8'hAA);
endmodule

// File: tb/kbd_link_rx_tb_top.sv
module kbd_link_rx_tb_top;
  localparam int HALF = 20;
  localparam int FILT = 4;
  localparam int TMO  = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ps2_clk = 1'b1, ps2_dat = 1'b1, inhibit = 1'b0;
  logic key_valid, key_release, key_ext, ack, selftest, frame_err;
  logic [7:0] key_code;

  always #5 clk = ~clk;

  kbd_link_rx #(.SYNC_STAGES(2), .FILT_LEN(FILT), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst(rst), .ps2_clk_i(ps2_clk), .ps2_dat_i(ps2_dat),
    .inhibit_i(inhibit), .key_valid_o(key_valid), .key_code_o(key_code),
    .key_release_o(key_release), .key_ext_o(key_ext), .ack_o(ack),
    .selftest_o(selftest), .frame_err_o(frame_err)
  );

  // kind: 0 key, 1 ack, 2 self-test, 3 error
  typedef struct packed { logic [1:0] kind; logic [7:0] code; logic rel; logic ext; } item_t;
  item_t exp_q[$];
  string tag_q[$];
  int checks = 0, failures = 0;
  bit done = 0;

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [1:0] k, input logic [7:0] c, input logic r, input logic e, input string tag);
    exp_q.push_back('{kind: k, code: c, rel: r, ext: e});
    tag_q.push_back(tag);
  endtask

  task automatic send_bits(input logic [10:0] f, input int n);
    for (int i = 0; i < n; i++) begin
      ps2_dat = f[i];
      wait_cyc(HALF);
      ps2_clk = 1'b0;
      wait_cyc(HALF);
      ps2_clk = 1'b1;
    end
    ps2_dat = 1'b1;
    wait_cyc(HALF);
  endtask

  task automatic send_byte(input logic [7:0] d, input logic bad_par = 1'b0, input logic bad_stop = 1'b0);
    logic p;
    p = (~^d) ^ bad_par;
    send_bits({~bad_stop, p, d, 1'b0}, 11);
    wait_cyc(2 * HALF);
  endtask

  // Monitor: pops the scoreboard on every output strobe.
  always @(negedge clk) begin
    if (!rst && (key_valid || ack || selftest || frame_err)) begin
      item_t got;
      got.kind = key_valid ? 2'd0 : ack ? 2'd1 : selftest ? 2'd2 : 2'd3;
      got.code = key_valid ? key_code : 8'h00;
      got.rel  = key_valid ? key_release : 1'b0;
      got.ext  = key_valid ? key_ext : 1'b0;
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL unexpected output: actual kind=%0d code=%h rel=%b ext=%b, expected nothing",
                 got.kind, got.code, got.rel, got.ext);
      end else begin
        item_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (got != e) begin
          failures++;
          $display("FAIL %s: actual kind=%0d code=%h rel=%b ext=%b, expected kind=%0d code=%h rel=%b ext=%b",
                   t, got.kind, got.code, got.rel, got.ext, e.kind, e.code, e.rel, e.ext);
        end
      end
    end
  end

  task automatic drained(input string tag);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL %s: actual %0d items outstanding, expected 0", tag, exp_q.size());
      exp_q.delete();
      tag_q.delete();
    end
  endtask

  initial begin
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(2);
    // R13 reset state
    checks++;
    if ({key_valid, key_code, key_release, key_ext, ack, selftest, frame_err} != '0) begin
      failures++;
      $display("FAIL R13: actual %b, expected all zero",
               {key_valid, key_code, key_release, key_ext, ack, selftest, frame_err});
    end
    wait_cyc(20);

    push(0, 8'h1C, 0, 0, "R2 plain press"); send_byte(8'h1C);
    push(0, 8'h35, 0, 0, "R1 data order"); send_byte(8'h35);
    push(0, 8'h1C, 1, 0, "R3 release"); send_byte(8'hF0); send_byte(8'h1C);
    push(0, 8'h75, 0, 1, "R4 extended press"); send_byte(8'hE0); send_byte(8'h75);
    push(0, 8'h75, 1, 1, "R4 extended release"); send_byte(8'hE0); send_byte(8'hF0); send_byte(8'h75);
    push(0, 8'h75, 0, 0, "R5 prefix cleared"); send_byte(8'h75);
    push(1, 8'h00, 0, 0, "R6 ack"); send_byte(8'hFA);
    push(2, 8'h00, 0, 0, "R7 self-test"); send_byte(8'hAA);
    push(1, 8'h00, 0, 0, "R6 ack after prefix"); send_byte(8'hF0); send_byte(8'hFA);
    push(0, 8'h2B, 0, 0, "R6 ack clears prefix"); send_byte(8'h2B);
    push(2, 8'h00, 0, 0, "R7 self-test after prefix"); send_byte(8'hE0); send_byte(8'hAA);
    push(0, 8'h2C, 0, 0, "R7 self-test clears prefix"); send_byte(8'h2C);
    push(3, 8'h00, 0, 0, "R8 bad parity"); send_byte(8'hF0); send_byte(8'h33, 1'b1, 1'b0);
    push(0, 8'h33, 0, 0, "R8 error clears prefix"); send_byte(8'h33);
    push(3, 8'h00, 0, 0, "R8 bad stop"); send_byte(8'h44, 1'b0, 1'b1);
    push(0, 8'h44, 0, 0, "R8 recovery"); send_byte(8'h44);
    push(3, 8'h00, 0, 0, "R9 bad start"); send_bits(11'h7FF, 1); wait_cyc(2 * HALF);
    push(0, 8'h5A, 0, 0, "R9 recovery"); send_byte(8'h5A);

    // R12: short low pulse while idle with data high must not read as a start bit of 1
    ps2_clk = 1'b0; wait_cyc(FILT - 2); ps2_clk = 1'b1; wait_cyc(2 * HALF);
    drained("R12 glitch ignored");
    push(0, 8'h12, 0, 0, "R12 frame after glitch"); send_byte(8'h12);

    // R11: partial frame then long gap
    send_bits({1'b1, 1'b1, 8'hFF, 1'b0}, 5);
    wait_cyc(TMO + 50);
    drained("R11 no error on timeout");
    push(0, 8'h4B, 0, 0, "R11 frame after timeout"); send_byte(8'h4B);

    // R10: inhibit mid-frame, host holds clock low
    send_bits({1'b1, 1'b1, 8'h00, 1'b0}, 4);
    inhibit = 1'b1;
    ps2_clk = 1'b0; wait_cyc(30);
    ps2_clk = 1'b1; wait_cyc(10);
    inhibit = 1'b0;
    wait_cyc(HALF);
    drained("R10 inhibit silent");
    push(0, 8'h29, 0, 0, "R10 frame after inhibit"); send_byte(8'h29);

    wait_cyc(50);
    drained("R2 all events seen");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule